// File: doc/BRIEF.md
# Split-Carry 32/16-bit Adder-Subtractor

This unit adds or subtracts two 32-bit operands, with a carry chain that can be broken between bit 15 and bit 16. With the chain joined, it works as one full-width adder/subtractor for transform and multiply-accumulate arithmetic. With the chain broken, it works as two independent 16-bit lanes for branch-metric and path-metric updates. A 3-bit operation code picks the arrangement, the direction (add or subtract) and the operand pairing. Two of the codes pair one half of X with the opposite half of Y.

Subtraction adds the inverted second operand and forces a carry-in of one into each active lane. A lane's carry flag is therefore the true carry on addition and "no borrow" on subtraction. Operands and the operation code are sampled on a rising edge, and the result and flags are registered on that same edge.

Top module: `split_addsub`

## Requirements
- R1: A synchronous active-high reset clears the result and both carry flags to zero by the next rising edge.
- R2: The result and flags change only on a rising edge, and reflect the operands and operation code present just before that edge.
- R3: Codes 0 (add) and 1 (subtract) work on the low halves only: result[15:0] = X[15:0] ± Y[15:0] modulo 2^16, result[31:16] = 0, flag[1] = 0, flag[0] = lane carry. On subtraction, flag[0] = 1 exactly when X[15:0] >= Y[15:0].
- R4: Codes 2 (add) and 3 (subtract) give result = X ± Y modulo 2^32. Flag[1] is the carry out of bit 31, and flag[0] is the internal carry from bit 15 into bit 16.
- R5: Codes 4 (add) and 5 (subtract) run both 16-bit lanes separately, each lane as in R3. No carry or borrow passes from bit 15 into bit 16, and flag[1] is the upper lane's carry.
- R6: Code 6 gives result[15:0] = X[31:16] − Y[15:0] modulo 2^16, result[31:16] = 0, flag[0] = 1 exactly when X[31:16] >= Y[15:0], and flag[1] = 0.
- R7: Code 7 gives result[15:0] = X[15:0] − Y[31:16] modulo 2^16, result[31:16] = 0, flag[0] = 1 exactly when X[15:0] >= Y[31:16], and flag[1] = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | 32 | First operand (minuend on subtraction) |
| y_i | input | 32 | Second operand (subtrahend on subtraction) |
| mode_i | input | 3 | Operation code, 0 to 7, as listed in R3 to R7 |
| res_o | output | 32 | Registered result |
| cout_o | output | 2 | Registered per-lane carry flags; bit 0 is the lower lane |

## Verification
The properties assume that the operands and the operation code are driven to known values in every cycle outside reset. They also assume that reset is held for at least one edge before any operation is checked, so that each single-cycle look-back sees a real input. The stimulus changes inputs only on falling edges and never leaves an input undriven. It sweeps all eight codes over carry-critical half-word values (0, 1, all ones, sign boundaries, mixed patterns) in every combination of halves. A second reset is applied mid-stream.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD_LO   = 3'd0,
    OP_SUB_LO   = 3'd1,
    OP_ADD_FULL = 3'd2,
    OP_SUB_FULL = 3'd3,
    OP_ADD_DUAL = 3'd4,
    OP_SUB_DUAL = 3'd5,
    OP_XSUB_HL  = 3'd6,
    OP_XSUB_LH  = 3'd7
  } op_e;

  typedef struct packed {
    logic sub;        // invert second operand, force lane carry-in
    logic split;      // cut the chain between the lanes
    logic hi_live;    // upper lane result is kept
    logic a_from_hi;  // lower lane takes X upper half
    logic b_from_hi;  // lower lane takes Y upper half
  } ctl_t;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
  import addsub_pkg::*;
(
  input  logic [2:0] op_i,
  output ctl_t       ctl_o
);

  always_comb begin
    ctl_o = '0;
    unique case (op_e'(op_i))
      OP_ADD_LO:   ctl_o = '{sub:1'b0, split:1'b1, hi_live:1'b0, a_from_hi:1'b0, b_from_hi:1'b0};
      OP_SUB_LO:   ctl_o = '{sub:1'b1, split:1'b1, hi_live:1'b0, a_from_hi:1'b0, b_from_hi:1'b0};
      OP_ADD_FULL: ctl_o = '{sub:1'b0, split:1'b0, hi_live:1'b1, a_from_hi:1'b0, b_from_hi:1'b0};
      OP_SUB_FULL: ctl_o = '{sub:1'b1, split:1'b0, hi_live:1'b1, a_from_hi:1'b0, b_from_hi:1'b0};
      OP_ADD_DUAL: ctl_o = '{sub:1'b0, split:1'b1, hi_live:1'b1, a_from_hi:1'b0, b_from_hi:1'b0};
      OP_SUB_DUAL: ctl_o = '{sub:1'b1, split:1'b1, hi_live:1'b1, a_from_hi:1'b0, b_from_hi:1'b0};
      OP_XSUB_HL:  ctl_o = '{sub:1'b1, split:1'b1, hi_live:1'b0, a_from_hi:1'b1, b_from_hi:1'b0};
      OP_XSUB_LH:  ctl_o = '{sub:1'b1, split:1'b1, hi_live:1'b0, a_from_hi:1'b0, b_from_hi:1'b1};
      default:     ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/addsub_lane.sv
module addsub_lane #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              inv_i,
  input  logic              cin_i,
  output logic [LANE_W-1:0] sum_o,
  output logic              cout_o
);

  logic [LANE_W-1:0] b_eff;
  logic [LANE_W:0]   total;

  always_comb begin
    b_eff = b_i ^ {LANE_W{inv_i}};
    total = {1'b0, a_i} + {1'b0, b_eff} + {{LANE_W{1'b0}}, cin_i};
  end

  assign sum_o  = total[LANE_W-1:0];
  assign cout_o = total[LANE_W];

endmodule

// File: rtl/addsub_outreg.sv
module addsub_outreg #(
  parameter int WIDTH = 32,
  parameter int FLAGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  input  logic [FLAGS-1:0] f_i,
  output logic [WIDTH-1:0] q_o,
  output logic [FLAGS-1:0] fq_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o  <= '0;
      fq_o <= '0;
    end else begin
      q_o  <= d_i;
      fq_o <= f_i;
    end
  end

endmodule

// File: rtl/split_addsub.sv
module split_addsub
  import addsub_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int NLANE = 2,
  localparam int DW    = NLANE * LANE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [2:0]    mode_i,
  output logic [DW-1:0] res_o,
  output logic [1:0]    cout_o
);

  ctl_t ctl;

  logic [NLANE-1:0][LANE_W-1:0] opa, opb, sum;
  logic [NLANE-1:0]             cin, cout;
  logic [LANE_W-1:0]            x_lo, x_hi, y_lo, y_hi;
  logic [DW-1:0]                res_d;
  logic [1:0]                   flg_d;

  addsub_decode u_dec (
    .op_i  (mode_i),
    .ctl_o (ctl)
  );

  assign x_lo = x_i[LANE_W-1:0];
  assign x_hi = x_i[DW-1:LANE_W];
  assign y_lo = y_i[LANE_W-1:0];
  assign y_hi = y_i[DW-1:LANE_W];

  // lane 0 operands may be taken from either half (cross-half pairing)
  assign opa[0] = ctl.a_from_hi ? x_hi : x_lo;
  assign opb[0] = ctl.b_from_hi ? y_hi : y_lo;
  assign opa[1] = x_hi;
  assign opb[1] = y_hi;

  // the lower lane always starts the chain; the upper lane either restarts
  // or continues from the lower lane's carry
  assign cin[0] = ctl.sub;
  assign cin[1] = ctl.split ? ctl.sub : cout[0];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    addsub_lane #(.LANE_W(LANE_W)) u_lane (
      .a_i    (opa[g]),
      .b_i    (opb[g]),
      .inv_i  (ctl.sub),
      .cin_i  (cin[g]),
      .sum_o  (sum[g]),
      .cout_o (cout[g])
    );
  end

  assign res_d = {(ctl.hi_live ? sum[1] : {LANE_W{1'b0}}), sum[0]};
  assign flg_d = {ctl.hi_live & cout[1], cout[0]};

  addsub_outreg #(.WIDTH(DW), .FLAGS(2)) u_out (
    .clk  (clk),
    .rst  (rst),
    .d_i  (res_d),
    .f_i  (flg_d),
    .q_o  (res_o),
    .fq_o (cout_o)
  );

endmodule

// File: rtl/split_addsub_chk.sv
module split_addsub_chk #(
  parameter int LANE_W = 16,
  localparam int DW = 2 * LANE_W
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] x_i,
  input logic [DW-1:0] y_i,
  input logic [2:0]    mode_i,
  input logic [DW-1:0] res_o,
  input logic [1:0]    cout_o
);

  // R3, R6, R7: single-lane codes leave the upper half and its flag clear
  p_single_hi_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd0 || mode_i == 3'd1 || mode_i == 3'd6 || mode_i == 3'd7)
    |=> (res_o[DW-1:LANE_W] == '0 && cout_o[1] == 1'b0));

  // R4: full-width add
  p_full_add_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd2) |=> (res_o == DW'($past(x_i) + $past(y_i))));

  // R4: full-width subtract
  p_full_sub_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd3) |=> (res_o == DW'($past(x_i) - $past(y_i))));

  // R5: upper lane of dual add ignores the lower lane
  p_dual_iso_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd4) |=> (res_o[DW-1:LANE_W] ==
      LANE_W'($past(x_i[DW-1:LANE_W]) + $past(y_i[DW-1:LANE_W]))));

  // R5: upper lane borrow flag on dual subtract
  p_dual_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd5) |=> (cout_o[1] ==
      ($past(x_i[DW-1:LANE_W]) >= $past(y_i[DW-1:LANE_W]))));

  // R6: X upper minus Y lower
  p_cross_hl_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd6) |=> (res_o[LANE_W-1:0] ==
      LANE_W'($past(x_i[DW-1:LANE_W]) - $past(y_i[LANE_W-1:0]))));

  // R7: X lower minus Y upper, with no-borrow flag
  p_cross_lh_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd7) |=> (cout_o[0] ==
      ($past(x_i[LANE_W-1:0]) >= $past(y_i[DW-1:LANE_W]))));

endmodule

bind split_addsub split_addsub_chk #(.LANE_W(LANE_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .x_i    (x_i),
  .y_i    (y_i),
  .mode_i (mode_i),
  .res_o  (res_o),
  .cout_o (cout_o)
);

// File: tb/split_addsub_test.sv
`timescale 1ns/1ps
module split_addsub_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] x = '0, y = '0;
  logic [2:0]  mode = '0;
  logic [31:0] res;
  logic [1:0]  cf;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;   // 125 MHz

  split_addsub uut (
    .clk(clk), .rst(rst), .x_i(x), .y_i(y), .mode_i(mode),
    .res_o(res), .cout_o(cf)
  );

  function automatic logic [15:0] pat(input int i);
    case (i)
      0: pat = 16'h0000;
      1: pat = 16'h0001;
      2: pat = 16'h7FFF;
      3: pat = 16'h8000;
      4: pat = 16'hFFFF;
      5: pat = 16'hFFFE;
      6: pat = 16'h1234;
      default: pat = 16'hABCD;
    endcase
  endfunction

  function automatic logic [16:0] add17(input logic [15:0] a, input logic [15:0] b, input logic s);
    add17 = s ? ({1'b0, a} + {1'b0, ~b} + 17'd1) : ({1'b0, a} + {1'b0, b});
  endfunction

  task automatic model(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic [1:0] c, output string tag);
    logic [16:0] s0, s1;
    logic [32:0] f;
    case (m)
      3'd0, 3'd1: begin s0 = add17(a[15:0], b[15:0], m[0]);
        r = {16'h0, s0[15:0]}; c = {1'b0, s0[16]}; tag = "R3"; end
      3'd2, 3'd3: begin
        f  = m[0] ? ({1'b0, a} + {1'b0, ~b} + 33'd1) : ({1'b0, a} + {1'b0, b});
        s0 = add17(a[15:0], b[15:0], m[0]);
        r = f[31:0]; c = {f[32], s0[16]}; tag = "R4"; end
      3'd4, 3'd5: begin s0 = add17(a[15:0], b[15:0], m[0]);
        s1 = add17(a[31:16], b[31:16], m[0]);
        r = {s1[15:0], s0[15:0]}; c = {s1[16], s0[16]}; tag = "R5"; end
      3'd6: begin s0 = add17(a[31:16], b[15:0], 1'b1);
        r = {16'h0, s0[15:0]}; c = {1'b0, s0[16]}; tag = "R6"; end
      default: begin s0 = add17(a[15:0], b[31:16], 1'b1);
        r = {16'h0, s0[15:0]}; c = {1'b0, s0[16]}; tag = "R7"; end
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic [1:0] ec);
    total++;
    if (res !== er || cf !== ec) begin
      bad++;
      $display("FAIL %s mode=%0d x=%h y=%h got res=%h c=%b exp res=%h c=%b",
               tag, mode, x, y, res, cf, er, ec);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] er, pr;
    logic [1:0]  ec, pc;
    string       tag;
    repeat (3) @(negedge clk);
    check("R1", 32'h0, 2'b00);           // R1: reset state
    rst = 1'b0;
    pr = '0; pc = '0;
    for (int m = 0; m < 8; m++) begin
      for (int xi = 0; xi < 64; xi++) begin
        for (int yi = 0; yi < 64; yi++) begin
          @(negedge clk);
          mode = 3'(m);
          x = {pat(xi / 8), pat(xi % 8)};
          y = {pat(yi / 8), pat(yi % 8)};
          #1;
          if (yi % 8 == 0) check("R2", pr, pc);   // R2: no change before the edge
          model(mode, x, y, er, ec, tag);
          @(negedge clk);
          check(tag, er, ec);
          pr = er; pc = ec;
        end
      end
    end
    // R1: reset in mid-stream clears a non-zero result
    @(negedge clk);
    mode = 3'd2; x = 32'hFFFF_FFFF; y = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R4", 32'hFFFF_FFFE, 2'b11);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 32'h0, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule